// File: doc/BRIEF.md
# Low-Power Card Presence Sequencer

This block lets a contactless reader front end look for a card while using very little power. It repeats two phases. In the standby phase it counts off a programmed number of millisecond ticks with the measurement front end switched off. In the detection phase it turns the front end on for a programmed number of microsecond ticks. At the end of each detection phase it captures the digital I and Q channel magnitudes. It then checks each value against a minimum/maximum window. A card, or any metal object that detunes the field, moves a value out of its window. When that happens the sequencer stops, sets a sticky interrupt flag and drives its interrupt pin, so the host can wake up and start normal reader operation.

The host uses a small byte-wide register bus. The windows are normally set by a calibration command. This command runs one detection phase with the field empty, stores the baseline, and writes the baseline minus the margin and the baseline plus the margin as the window limits, saturated to the 6-bit range. The host can run a single standby/detect pass or keep cycling until something is detected. An abort command returns the sequencer to idle at any time.

Top module: `card_sense_seq`

Register map (8-bit data, `reg_rdata` is registered and shows the register addressed in the previous cycle):

| Addr | Contents |
|---|---|
| 07h | interrupt flags; bit 5 = detection (sticky, write 1 to clear) |
| 30h/31h | standby length in ms ticks, low/high byte |
| 32h/33h | detection length in µs ticks, low/high byte |
| 34h | bits 2:0 = window margin |
| 35h | command: 01h start, 02h calibrate, 03h abort |
| 36h | bit 0 = repeat mode (1 = cycle until detection) |
| 37h | bit 0 = busy |
| 3Fh | [7:6] I-max bits 5:4, [5:0] Q-min |
| 40h | [7:6] I-max bits 3:2, [5:0] Q-max |
| 41h | [7:6] I-max bits 1:0, [5:0] I-min |
| 42h/43h | captured I / Q value in bits 5:0 |

## Requirements
- R1: After reset, 30h reads 0Ah, 31h reads 00h, 32h reads 96h, 33h reads 00h (10 ms standby and 150 µs detection), 34h reads 01h, 36h, 37h and 07h read 00h, and irq_o and meas_en are low.
- R2: After a start command, meas_en stays low for exactly the programmed number of tick_ms pulses. It then stays high for exactly the programmed number of tick_us pulses. A length of 0 behaves like a length of 1.
- R3: When a detection or calibration phase ends, meas_i and meas_q are latched into bits 5:0 of 42h and 43h. Those registers do not change at any other time.
- R4: A detection phase reports a detection only when I < I-min, I > I-max, Q < Q-min or Q > Q-max; values on a limit count as inside. A detection sets bit 5 of 07h, raises irq_o and returns the sequencer to idle (37h bit 0 = 0).
- R5: Q-min, Q-max and I-min are in bits 5:0 of 3Fh, 40h and 41h. I-max bits 5:4, 3:2 and 1:0 are in bits 7:6 of 3Fh, 40h and 41h. The registers read back as written.
- R6: With 36h bit 0 = 0, one standby/detect pass without detection returns to idle with the flag clear. With 36h bit 0 = 1, passes repeat until a detection occurs.
- R7: The calibrate command runs one detection phase with no comparison and never sets the flag. It writes I-min/Q-min = baseline − margin (floored at 0) and I-max/Q-max = baseline + margin (capped at 63).
- R8: Writing 07h with bit 5 = 1 clears the flag and lowers irq_o. A write with bit 5 = 0 leaves the flag set.
- R9: The abort command (03h to 35h) returns the sequencer to idle from standby or detection. meas_en is low from the next cycle on, and the flag is not set.
- R10: Start and calibrate commands written while the sequencer is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_ms | input | 1 | one-cycle millisecond strobe, paces standby |
| tick_us | input | 1 | one-cycle microsecond strobe, paces detection |
| meas_i | input | 6 | I channel magnitude from the measurement front end |
| meas_q | input | 6 | Q channel magnitude from the measurement front end |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 8 | register address |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | registered read data for the previous address |
| meas_en | output | 1 | front end enable, high during detection and calibration |
| irq_o | output | 1 | interrupt request, follows the sticky detection flag |

## Verification
The assertions assume reset is held for at least one clock and that every tick arrives as a one-cycle strobe in step with clk. They also assume the measurement inputs hold their values for the whole detection window, because the capture and the window comparison both use the values present at the end of that window. The stimulus keeps meas_i and meas_q constant whenever meas_en is high and changes them only in standby or idle. It holds both tick strobes high every cycle, so phase lengths can be counted in clock cycles, and it issues abort only through the normal command register.

// File: rtl/card_sense_pkg.sv
package card_sense_pkg;
  localparam int VW = 6;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int CW = 16;
  localparam int MW = 3;

  typedef enum logic [1:0] {S_IDLE, S_STBY, S_DET, S_CAL} seq_st_t;

  localparam logic [AW-1:0] A_IRQ  = 8'h07;
  localparam logic [AW-1:0] A_STBL = 8'h30;
  localparam logic [AW-1:0] A_STBH = 8'h31;
  localparam logic [AW-1:0] A_DETL = 8'h32;
  localparam logic [AW-1:0] A_DETH = 8'h33;
  localparam logic [AW-1:0] A_MARG = 8'h34;
  localparam logic [AW-1:0] A_CMD  = 8'h35;
  localparam logic [AW-1:0] A_MODE = 8'h36;
  localparam logic [AW-1:0] A_STAT = 8'h37;
  localparam logic [AW-1:0] A_THA  = 8'h3F;
  localparam logic [AW-1:0] A_THB  = 8'h40;
  localparam logic [AW-1:0] A_THC  = 8'h41;
  localparam logic [AW-1:0] A_RESI = 8'h42;
  localparam logic [AW-1:0] A_RESQ = 8'h43;

  localparam logic [DW-1:0] C_START = 8'h01;
  localparam logic [DW-1:0] C_CAL   = 8'h02;
  localparam logic [DW-1:0] C_ABORT = 8'h03;
  localparam int IRQ_BIT = 5;

  function automatic logic [VW-1:0] sat_down(input logic [VW-1:0] b, input logic [MW-1:0] m);
    logic [VW:0] d;
    d = {1'b0, b} - {{(VW+1-MW){1'b0}}, m};
    return d[VW] ? '0 : d[VW-1:0];
  endfunction

  function automatic logic [VW-1:0] sat_up(input logic [VW-1:0] b, input logic [MW-1:0] m);
    logic [VW:0] s;
    s = {1'b0, b} + {{(VW+1-MW){1'b0}}, m};
    return s[VW] ? '1 : s[VW-1:0];
  endfunction
endpackage

// File: rtl/card_sense_timer.sv
module card_sense_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign done = tick && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && !done) cnt <= nxt[CW-1:0];
  end
endmodule

// File: rtl/card_sense_regs.sv
module card_sense_regs
  import card_sense_pkg::*;
#(
  parameter int VW = card_sense_pkg::VW,
  parameter int DW = card_sense_pkg::DW,
  parameter int AW = card_sense_pkg::AW,
  parameter int CW = card_sense_pkg::CW,
  parameter int MW = card_sense_pkg::MW,
  parameter logic [CW-1:0] STBY_RST = 10,
  parameter logic [CW-1:0] DET_RST  = 150,
  parameter logic [MW-1:0] MARG_RST = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          det_set,
  input  logic          thr_load,
  input  logic [VW-1:0] ld_imin,
  input  logic [VW-1:0] ld_imax,
  input  logic [VW-1:0] ld_qmin,
  input  logic [VW-1:0] ld_qmax,
  input  logic [VW-1:0] res_i,
  input  logic [VW-1:0] res_q,
  output logic [CW-1:0] stby_len,
  output logic [CW-1:0] det_len,
  output logic [MW-1:0] margin,
  output logic          cycling,
  output logic [VW-1:0] imin,
  output logic [VW-1:0] imax,
  output logic [VW-1:0] qmin,
  output logic [VW-1:0] qmax,
  output logic          irq_flag,
  output logic          cmd_start,
  output logic          cmd_cal,
  output logic          cmd_abort,
  output logic          irq_w1c
);
  localparam int PW = DW - VW;
  localparam int HW = CW - DW;

  logic cmd_wr;
  assign cmd_wr    = we && (addr == A_CMD);
  assign cmd_start = cmd_wr && (wdata == C_START) && !busy;
  assign cmd_cal   = cmd_wr && (wdata == C_CAL) && !busy;
  assign cmd_abort = cmd_wr && (wdata == C_ABORT);
  assign irq_w1c   = we && (addr == A_IRQ) && wdata[IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_len <= STBY_RST;
      det_len  <= DET_RST;
      margin   <= MARG_RST;
      cycling  <= 1'b0;
    end else if (we) begin
      case (addr)
        A_STBL: stby_len[DW-1:0] <= wdata;
        A_STBH: stby_len[CW-1:DW] <= wdata[HW-1:0];
        A_DETL: det_len[DW-1:0] <= wdata;
        A_DETH: det_len[CW-1:DW] <= wdata[HW-1:0];
        A_MARG: margin <= wdata[MW-1:0];
        A_MODE: cycling <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imin <= '0;
      imax <= '0;
      qmin <= '0;
      qmax <= '0;
    end else if (thr_load) begin
      imin <= ld_imin;
      imax <= ld_imax;
      qmin <= ld_qmin;
      qmax <= ld_qmax;
    end else if (we) begin
      case (addr)
        A_THA: begin
          qmin <= wdata[VW-1:0];
          imax[VW-1 -: PW] <= wdata[DW-1:VW];
        end
        A_THB: begin
          qmax <= wdata[VW-1:0];
          imax[VW-1-PW -: PW] <= wdata[DW-1:VW];
        end
        A_THC: begin
          imin <= wdata[VW-1:0];
          imax[PW-1:0] <= wdata[DW-1:VW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_flag <= 1'b0;
    else if (det_set) irq_flag <= 1'b1;
    else if (irq_w1c) irq_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      case (addr)
        A_IRQ:  rdata[IRQ_BIT] <= irq_flag;
        A_STBL: rdata <= stby_len[DW-1:0];
        A_STBH: rdata[HW-1:0] <= stby_len[CW-1:DW];
        A_DETL: rdata <= det_len[DW-1:0];
        A_DETH: rdata[HW-1:0] <= det_len[CW-1:DW];
        A_MARG: rdata[MW-1:0] <= margin;
        A_MODE: rdata[0] <= cycling;
        A_STAT: rdata[0] <= busy;
        A_THA:  rdata <= {imax[VW-1 -: PW], qmin};
        A_THB:  rdata <= {imax[VW-1-PW -: PW], qmax};
        A_THC:  rdata <= {imax[PW-1:0], imin};
        A_RESI: rdata[VW-1:0] <= res_i;
        A_RESQ: rdata[VW-1:0] <= res_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/card_sense_fsm.sv
module card_sense_fsm
  import card_sense_pkg::*;
#(
  parameter int VW = card_sense_pkg::VW,
  parameter int CW = card_sense_pkg::CW,
  parameter int MW = card_sense_pkg::MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          tick_us,
  input  logic          start,
  input  logic          cal,
  input  logic          abort,
  input  logic          cycling,
  input  logic [CW-1:0] stby_len,
  input  logic [CW-1:0] det_len,
  input  logic [MW-1:0] margin,
  input  logic [VW-1:0] meas_i,
  input  logic [VW-1:0] meas_q,
  input  logic [VW-1:0] imin,
  input  logic [VW-1:0] imax,
  input  logic [VW-1:0] qmin,
  input  logic [VW-1:0] qmax,
  output logic          busy,
  output logic          meas_en,
  output logic [VW-1:0] res_i,
  output logic [VW-1:0] res_q,
  output logic          det_set,
  output logic          thr_load,
  output logic [VW-1:0] ld_imin,
  output logic [VW-1:0] ld_imax,
  output logic [VW-1:0] ld_qmin,
  output logic [VW-1:0] ld_qmax
);
  seq_st_t       state;
  logic          ph_tick, tmr_done, ph_done, outside;
  logic [CW-1:0] ph_lim;

  assign ph_tick = (state == S_STBY) ? tick_ms : tick_us;
  assign ph_lim  = (state == S_STBY) ? stby_len : det_len;

  card_sense_timer #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  ((state == S_IDLE) || ph_done || abort),
    .tick (ph_tick),
    .limit(ph_lim),
    .done (tmr_done)
  );

  assign ph_done = tmr_done && (state != S_IDLE);
  assign outside = (meas_i < imin) || (meas_i > imax) ||
                   (meas_q < qmin) || (meas_q > qmax);
  assign busy     = (state != S_IDLE);
  assign meas_en  = (state == S_DET) || (state == S_CAL);
  assign det_set  = (state == S_DET) && ph_done && outside && !abort;
  assign thr_load = (state == S_CAL) && ph_done && !abort;
  assign ld_imin  = sat_down(meas_i, margin);
  assign ld_imax  = sat_up(meas_i, margin);
  assign ld_qmin  = sat_down(meas_q, margin);
  assign ld_qmax  = sat_up(meas_q, margin);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      res_i <= '0;
      res_q <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) state <= S_STBY;
          else if (cal) state <= S_CAL;
        end
        S_STBY: if (ph_done) state <= S_DET;
        S_DET: begin
          if (ph_done) begin
            res_i <= meas_i;
            res_q <= meas_q;
            if (outside || !cycling) state <= S_IDLE;
            else state <= S_STBY;
          end
        end
        default: begin
          if (ph_done) begin
            res_i <= meas_i;
            res_q <= meas_q;
            state <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/card_sense_seq.sv
module card_sense_seq
  import card_sense_pkg::*;
#(
  parameter int VW = card_sense_pkg::VW,
  parameter int DW = card_sense_pkg::DW,
  parameter int AW = card_sense_pkg::AW,
  parameter int CW = card_sense_pkg::CW,
  parameter int MW = card_sense_pkg::MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          tick_us,
  input  logic [VW-1:0] meas_i,
  input  logic [VW-1:0] meas_q,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          meas_en,
  output logic          irq_o
);
  logic          busy, det_set, thr_load, cycling, irq_flag;
  logic          cmd_start, cmd_cal, cmd_abort, irq_w1c;
  logic [VW-1:0] ld_imin, ld_imax, ld_qmin, ld_qmax;
  logic [VW-1:0] imin, imax, qmin, qmax, res_i, res_q;
  logic [CW-1:0] stby_len, det_len;
  logic [MW-1:0] margin;

  card_sense_regs #(.VW(VW), .DW(DW), .AW(AW), .CW(CW), .MW(MW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .det_set(det_set), .thr_load(thr_load),
    .ld_imin(ld_imin), .ld_imax(ld_imax), .ld_qmin(ld_qmin), .ld_qmax(ld_qmax),
    .res_i(res_i), .res_q(res_q), .stby_len(stby_len), .det_len(det_len),
    .margin(margin), .cycling(cycling), .imin(imin), .imax(imax),
    .qmin(qmin), .qmax(qmax), .irq_flag(irq_flag), .cmd_start(cmd_start),
    .cmd_cal(cmd_cal), .cmd_abort(cmd_abort), .irq_w1c(irq_w1c)
  );

  card_sense_fsm #(.VW(VW), .CW(CW), .MW(MW)) u_fsm (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .tick_us(tick_us),
    .start(cmd_start), .cal(cmd_cal), .abort(cmd_abort), .cycling(cycling),
    .stby_len(stby_len), .det_len(det_len), .margin(margin),
    .meas_i(meas_i), .meas_q(meas_q), .imin(imin), .imax(imax),
    .qmin(qmin), .qmax(qmax), .busy(busy), .meas_en(meas_en),
    .res_i(res_i), .res_q(res_q), .det_set(det_set), .thr_load(thr_load),
    .ld_imin(ld_imin), .ld_imax(ld_imax), .ld_qmin(ld_qmin), .ld_qmax(ld_qmax)
  );

  assign irq_o = irq_flag;
endmodule

// File: rtl/card_sense_seq_chk.sv
module card_sense_seq_chk #(
  parameter int VW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          meas_en,
  input logic          irq_o,
  input logic [VW-1:0] res_i,
  input logic [VW-1:0] res_q,
  input logic          cmd_abort,
  input logic          irq_w1c
);
  // R4: the flag only rises as a detection phase ends
  p_irq_after_detect_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(meas_en));

  // R9: abort drops the front end enable on the next cycle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> !meas_en);

  // R3: captured I value changes only when a detection window closes
  p_res_i_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(meas_en) |-> $stable(res_i));

  // R3: same for the Q value
  p_res_q_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(meas_en) |-> $stable(res_q));

  // R8: the flag stays set until a write-one clear
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o && !irq_w1c |=> irq_o);
endmodule

bind card_sense_seq card_sense_seq_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .meas_en(meas_en), .irq_o(irq_o),
  .res_i(res_i), .res_q(res_q), .cmd_abort(cmd_abort), .irq_w1c(irq_w1c)
);

// File: tb/card_sense_seq_bench.sv
module card_sense_seq_bench;
  import card_sense_pkg::*;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b1;
  logic       tick_us = 1'b1;
  logic [5:0] mi = '0;
  logic [5:0] mq = '0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wd = '0;
  wire  [7:0] rdata;
  wire        meas_en;
  wire        irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done_f = 1'b0;
  logic [7:0] r;

  always #(CLK_P/2) clk = ~clk;

  card_sense_seq u_card_sense_seq (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .tick_us(tick_us),
    .meas_i(mi), .meas_q(mq), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wd), .reg_rdata(rdata), .meas_en(meas_en), .irq_o(irq)
  );

  // {expected detect, imin, imax, qmin, qmax, meas_i, meas_q}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 6'd20, 6'd30, 6'd10, 6'd40, 6'd25, 6'd25},
    {1'b1, 6'd20, 6'd30, 6'd10, 6'd40, 6'd19, 6'd25},
    {1'b1, 6'd20, 6'd30, 6'd10, 6'd40, 6'd31, 6'd25},
    {1'b0, 6'd20, 6'd30, 6'd10, 6'd40, 6'd20, 6'd10},
    {1'b0, 6'd20, 6'd30, 6'd10, 6'd40, 6'd30, 6'd40},
    {1'b1, 6'd20, 6'd30, 6'd10, 6'd40, 6'd25, 6'd9},
    {1'b1, 6'd20, 6'd30, 6'd10, 6'd40, 6'd25, 6'd41},
    {1'b0, 6'd0,  6'd63, 6'd0,  6'd63, 6'd63, 6'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic set_thr(input logic [5:0] imn, input logic [5:0] imx,
                         input logic [5:0] qmn, input logic [5:0] qmx);
    wr(A_THA, {imx[5:4], qmn});
    wr(A_THB, {imx[3:2], qmx});
    wr(A_THC, {imx[1:0], imn});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_f) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq_o", irq, 0);
    chk("R1 meas_en", meas_en, 0);
    rd(A_STBL, r); chk("R1 standby low", r, 8'h0A);
    rd(A_STBH, r); chk("R1 standby high", r, 0);
    rd(A_DETL, r); chk("R1 detect low", r, 8'h96);
    rd(A_DETH, r); chk("R1 detect high", r, 0);
    rd(A_MARG, r); chk("R1 margin", r, 1);
    rd(A_MODE, r); chk("R1 mode", r, 0);
    rd(A_STAT, r); chk("R1 status", r, 0);
    rd(A_IRQ, r);  chk("R1 flag", r, 0);

    // R2 phase lengths, window wide open
    set_thr(6'd0, 6'd63, 6'd0, 6'd63);
    mi = 6'd12; mq = 6'd34;
    wr(A_STBL, 8'd3); wr(A_DETL, 8'd5);
    wr(A_CMD, C_START);
    begin
      int lo = 0;
      int hi = 0;
      while (!meas_en && lo < 100) begin lo++; @(negedge clk); end
      while (meas_en && hi < 100) begin hi++; @(negedge clk); end
      chk("R2 standby cycles", lo, 3);
      chk("R2 detect cycles", hi, 5);
    end
    wait_idle();
    chk("R6 one-shot no irq", irq, 0);
    rd(A_RESI, r); chk("R3 result I", r, 12);
    rd(A_RESQ, r); chk("R3 result Q", r, 34);

    // R2 zero length acts as one
    wr(A_STBL, 8'd0); wr(A_DETL, 8'd0);
    wr(A_CMD, C_START);
    begin
      int lo = 0;
      int hi = 0;
      while (!meas_en && lo < 100) begin lo++; @(negedge clk); end
      while (meas_en && hi < 100) begin hi++; @(negedge clk); end
      chk("R2 zero standby", lo, 1);
      chk("R2 zero detect", hi, 1);
    end
    wait_idle();

    // R4/R5/R3 vector table
    wr(A_STBL, 8'd2); wr(A_DETL, 8'd3);
    foreach (VEC[n]) begin
      logic [36:0] v;
      v = VEC[n];
      set_thr(v[35:30], v[29:24], v[23:18], v[17:12]);
      if (n == 0) begin
        rd(A_THA, r); chk("R5 reg 3Fh", r, {v[29:28], v[23:18]});
        rd(A_THB, r); chk("R5 reg 40h", r, {v[27:26], v[17:12]});
        rd(A_THC, r); chk("R5 reg 41h", r, {v[25:24], v[35:30]});
      end
      wr(A_IRQ, 8'h20);
      mi = v[11:6]; mq = v[5:0];
      wr(A_CMD, C_START);
      wait_idle();
      chk("R4 irq_o", irq, v[36]);
      rd(A_IRQ, r); chk("R4 flag bit5", r, {v[36], 5'b0});
      rd(A_RESI, r); chk("R3 vector I", r, v[11:6]);
      rd(A_RESQ, r); chk("R3 vector Q", r, v[5:0]);
    end

    // R6 repeat mode
    wr(A_IRQ, 8'h20);
    set_thr(6'd20, 6'd30, 6'd10, 6'd40);
    mi = 6'd25; mq = 6'd25;
    wr(A_MODE, 8'h01);
    wr(A_CMD, C_START);
    begin
      int rises = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (meas_en && !prev) rises++;
        prev = meas_en;
        @(negedge clk);
      end
      chk("R6 repeated passes", (rises >= 4) ? 1 : 0, 1);
    end
    chk("R6 no irq while cycling", irq, 0);
    while (meas_en) @(negedge clk);
    mi = 6'd50;
    wait_idle();
    chk("R6 stop on detect", irq, 1);
    rd(A_RESI, r); chk("R6 captured I", r, 50);
    wr(A_MODE, 8'h00);

    // R8 clear behaviour
    wr(A_IRQ, 8'h00);
    chk("R8 write zero keeps", irq, 1);
    wr(A_IRQ, 8'hDF);
    rd(A_IRQ, r); chk("R8 other bits keep", r, 8'h20);
    wr(A_IRQ, 8'h20);
    chk("R8 clear irq_o", irq, 0);
    rd(A_IRQ, r); chk("R8 clear flag", r, 0);

    // R7 calibration, saturating
    wr(A_MARG, 8'd3);
    mi = 6'd1; mq = 6'd62;
    wr(A_CMD, C_CAL);
    wait_idle();
    chk("R7 no irq", irq, 0);
    rd(A_THA, r); chk("R7 sat 3Fh", r, 8'h3B);
    rd(A_THB, r); chk("R7 sat 40h", r, 8'h7F);
    rd(A_THC, r); chk("R7 sat 41h", r, 8'h00);
    rd(A_RESQ, r); chk("R7 baseline Q", r, 62);

    // R7 calibration, mid range, margin 4
    wr(A_MARG, 8'd4);
    mi = 6'd40; mq = 6'd20;
    wr(A_CMD, C_CAL);
    wait_idle();
    rd(A_THA, r); chk("R7 mid 3Fh", r, 8'h90);
    rd(A_THB, r); chk("R7 mid 40h", r, 8'hD8);
    rd(A_THC, r); chk("R7 mid 41h", r, 8'h24);

    // R9 abort in standby, R10 ignored commands
    wr(A_STBL, 8'hE8); wr(A_STBH, 8'h03);
    wr(A_CMD, C_START);
    wr(A_CMD, C_CAL);
    begin
      int seen = 0;
      for (int k = 0; k < 5; k++) begin
        if (meas_en) seen++;
        @(negedge clk);
      end
      chk("R10 calibrate ignored", seen, 0);
    end
    rd(A_STAT, r); chk("R10 still busy", r, 1);
    wr(A_CMD, C_ABORT);
    rd(A_STAT, r); chk("R9 idle after abort", r, 0);

    // R9 abort in detection
    mi = 6'd60;
    wr(A_STBL, 8'd1); wr(A_STBH, 8'd0);
    wr(A_DETL, 8'hE8); wr(A_DETH, 8'h03);
    wr(A_CMD, C_START);
    while (!meas_en) @(negedge clk);
    wr(A_CMD, C_ABORT);
    chk("R9 meas_en low", meas_en, 0);
    repeat (3) @(negedge clk);
    chk("R9 no irq", irq, 0);
    rd(A_STAT, r); chk("R9 status idle", r, 0);

    done_f = 1'b1;
    summary();
    $finish;
  end
endmodule